// File: doc/BRIEF.md
# Sampled Program-Counter Trace Recorder

This block is a small debug recorder that sits beside a processor core. It watches a strobe that pulses once for each retired instruction, along with the program counter of that instruction. It keeps one PC out of every fixed number of retired steps and writes it into a circular history, so the history always covers the most recent stretch of execution at a coarse grain.

When a dump is requested, the recorder walks the whole history once. It starts at the oldest slot and ends at the newest. Slots that hold zero are treated as never written and are dropped. Runs of the same PC are folded into a single record that carries a repeat count. The records leave through a valid/ready stream, so a slow consumer such as a debug port can drain them at its own pace. While a dump is in progress, new samples are not taken, so the walk sees a fixed snapshot of the history.

Top module: `pctrace_recorder`

## Requirements
- R1: After `rst`, every history slot is zero, the write position is 0 and the step count is 0. A dump then produces no record, and `busy` returns to 0.
- R2: Each accepted step (`step_vld` high while `busy` is low) advances a step counter. On the `DECIM`-th accepted step, `step_pc` of that same step is written to the history, and the counter restarts at zero.
- R3: The history has `DEPTH` slots. The write position advances by one per sample and wraps from `DEPTH-1` to 0, so each new sample overwrites the oldest one.
- R4: A dump visits all `DEPTH` slots exactly once. It starts at the current write position, so records come out oldest first.
- R5: A slot holding the value zero is skipped and produces no record. Every record therefore has a non-zero `rec_pc`.
- R6: Equal PCs that follow each other in the walk form one record, with `rec_count` set to the number of slots merged. This holds even when empty slots lie between them. Two records next to each other in one dump never carry the same PC, and `rec_count` is always at least 1.
- R7: Once `rec_valid` is high, it stays high and `rec_pc`/`rec_count` stay unchanged until a cycle in which `rec_ready` is high.
- R8: While `busy` is high, `step_vld` is ignored. No sample is written and the step counter does not move.
- R9: A `dump_req` that arrives while `busy` is high is ignored. It does not start a second walk.
- R10: `clear` has the same effect as `rst`, including when a dump is in progress: the walk is abandoned and any pending record is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous restart; same effect as reset |
| step_vld | input | 1 | One retired instruction this cycle |
| step_pc | input | PC_W | PC of the retired instruction |
| dump_req | input | 1 | Start a readout walk (accepted when idle) |
| rec_ready | input | 1 | Consumer accepts the current record |
| rec_valid | output | 1 | A record is presented |
| rec_pc | output | PC_W | PC of the record |
| rec_count | output | CNT_W | Number of merged slots (1..DEPTH) |
| busy | output | 1 | A dump is in progress or a record is still pending |

## Verification
The hardest case to reach is a run of equal PCs that crosses the ring's wrap point and has empty slots inside it. The walk must also stall on a slow consumer at the same moment it has to flush the final run. The bench uses a reduced ring of 8 slots and a decimation of 3. It fills the ring with samples drawn from a four-value alphabet that includes zero, so runs, gaps and wraps come up repeatedly. Each dump is drained under one of four ready patterns, and steps and extra dump requests are fed in during the walk. A clear is also issued in the middle of a stalled walk.

// File: rtl/pctrace_pkg.sv
package pctrace_pkg;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_SCAN  = 2'd1,
        WK_FLUSH = 2'd2
    } walk_state_t;

    // advance a ring position of modulus n
    function automatic int unsigned wrap_inc(int unsigned v, int unsigned n);
        return (v + 1 >= n) ? 0 : v + 1;
    endfunction

endpackage

// File: rtl/pctrace_sampler.sv
module pctrace_sampler
    import pctrace_pkg::*;
#(
    parameter int DECIM = 500,
    parameter int DEPTH = 128,
    parameter int PC_W  = 32,
    localparam int CW   = $clog2(DECIM),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            freeze,
    input  logic            step_vld,
    input  logic [PC_W-1:0] step_pc,
    output logic            wr_en,
    output logic [AW-1:0]   wr_addr,
    output logic [PC_W-1:0] wr_data
);

    logic [CW-1:0] step_cnt;
    logic [AW-1:0] wptr;
    logic          take;

    assign take    = step_vld && !freeze;
    assign wr_en   = take && (step_cnt == CW'(DECIM - 1));
    assign wr_addr = wptr;
    assign wr_data = step_pc;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            step_cnt <= '0;
            wptr     <= '0;
        end else if (take) begin
            if (step_cnt == CW'(DECIM - 1)) begin
                step_cnt <= '0;
                wptr     <= AW'(wrap_inc(int'(wptr), DEPTH));
            end else begin
                step_cnt <= step_cnt + 1'b1;
            end
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst || clear)
        int'(step_cnt) < DECIM); // R2

    AST_FROZEN_SAMPLER: assert property (@(posedge clk) disable iff (rst || clear)
        freeze |=> $stable(step_cnt) && $stable(wptr)); // R8

endmodule

// File: rtl/pctrace_store.sv
module pctrace_store #(
    parameter int DEPTH = 128,
    parameter int PC_W  = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [PC_W-1:0] wr_data,
    input  logic [AW-1:0]   rd_addr,
    output logic [PC_W-1:0] rd_data
);

    logic [PC_W-1:0] slots [DEPTH];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            for (int i = 0; i < DEPTH; i++) slots[i] <= '0;
        end else if (wr_en) begin
            slots[wr_addr] <= wr_data;
        end
    end

    assign rd_data = slots[rd_addr];

endmodule

// File: rtl/pctrace_walker.sv
module pctrace_walker
    import pctrace_pkg::*;
#(
    parameter int DEPTH = 128,
    parameter int PC_W  = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             dump_req,
    input  logic [AW-1:0]    start_ptr,
    output logic [AW-1:0]    rd_addr,
    input  logic [PC_W-1:0]  slot_data,
    output logic             rec_valid,
    input  logic             rec_ready,
    output logic [PC_W-1:0]  rec_pc,
    output logic [CNT_W-1:0] rec_count,
    output logic             busy
);

    walk_state_t      state;
    logic [AW-1:0]    ptr;
    logic [AW-1:0]    visited;
    logic             run_open;
    logic [PC_W-1:0]  run_pc;
    logic [CNT_W-1:0] run_cnt;
    logic             out_vld;
    logic [PC_W-1:0]  out_pc;
    logic [CNT_W-1:0] out_cnt;
    logic             out_free;
    logic             slot_used;
    logic             same_run;

    assign out_free  = !out_vld || rec_ready;
    assign slot_used = (slot_data != '0);
    assign same_run  = run_open && (slot_data == run_pc);
    assign rd_addr   = ptr;
    assign rec_valid = out_vld;
    assign rec_pc    = out_pc;
    assign rec_count = out_cnt;
    assign busy      = (state != WK_IDLE) || out_vld;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state    <= WK_IDLE;
            ptr      <= '0;
            visited  <= '0;
            run_open <= 1'b0;
            run_pc   <= '0;
            run_cnt  <= '0;
            out_vld  <= 1'b0;
            out_pc   <= '0;
            out_cnt  <= '0;
        end else begin
            if (out_vld && rec_ready) out_vld <= 1'b0;
            unique case (state)
                WK_IDLE: begin
                    if (dump_req && !out_vld) begin
                        state    <= WK_SCAN;
                        ptr      <= start_ptr;
                        visited  <= '0;
                        run_open <= 1'b0;
                    end
                end
                WK_SCAN: begin
                    if (out_free) begin
                        if (slot_used) begin
                            if (same_run) begin
                                run_cnt <= run_cnt + 1'b1;
                            end else begin
                                if (run_open) begin
                                    out_vld <= 1'b1;
                                    out_pc  <= run_pc;
                                    out_cnt <= run_cnt;
                                end
                                run_open <= 1'b1;
                                run_pc   <= slot_data;
                                run_cnt  <= CNT_W'(1);
                            end
                        end
                        ptr     <= AW'(wrap_inc(int'(ptr), DEPTH));
                        visited <= visited + 1'b1;
                        if (visited == AW'(DEPTH - 1)) state <= WK_FLUSH;
                    end
                end
                WK_FLUSH: begin
                    if (out_free) begin
                        if (run_open) begin
                            out_vld <= 1'b1;
                            out_pc  <= run_pc;
                            out_cnt <= run_cnt;
                        end
                        run_open <= 1'b0;
                        state    <= WK_IDLE;
                    end
                end
                default: state <= WK_IDLE;
            endcase
        end
    end

    // last accepted record of the current dump, for the run-split check
    logic            prev_open;
    logic [PC_W-1:0] prev_pc;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            prev_open <= 1'b0;
            prev_pc   <= '0;
        end else if (state == WK_IDLE && dump_req && !out_vld) begin
            prev_open <= 1'b0;
        end else if (out_vld && rec_ready) begin
            prev_open <= 1'b1;
            prev_pc   <= out_pc;
        end
    end

    AST_REC_NONEMPTY: assert property (@(posedge clk) disable iff (rst || clear)
        rec_valid |-> (rec_pc != '0) && (rec_count != '0)); // R5

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst || clear)
        rec_valid && !rec_ready |=> rec_valid && $stable(rec_pc) && $stable(rec_count)); // R7

    AST_RUNS_SPLIT: assert property (@(posedge clk) disable iff (rst || clear)
        rec_valid && prev_open |-> rec_pc != prev_pc); // R6

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst || clear)
        (state == WK_SCAN) && dump_req && !out_free |=> $stable(ptr)); // R9

endmodule

// File: rtl/pctrace_recorder.sv
module pctrace_recorder #(
    parameter int DECIM = 500,
    parameter int DEPTH = 128,
    parameter int PC_W  = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step_vld,
    input  logic [PC_W-1:0]  step_pc,
    input  logic             dump_req,
    input  logic             rec_ready,
    output logic             rec_valid,
    output logic [PC_W-1:0]  rec_pc,
    output logic [CNT_W-1:0] rec_count,
    output logic             busy
);

    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [PC_W-1:0] wr_data;
    logic [AW-1:0]   rd_addr;
    logic [PC_W-1:0] rd_data;

    pctrace_sampler #(.DECIM(DECIM), .DEPTH(DEPTH), .PC_W(PC_W)) u_sampler (
        .clk      (clk),
        .rst      (rst),
        .clear    (clear),
        .freeze   (busy),
        .step_vld (step_vld),
        .step_pc  (step_pc),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    pctrace_store #(.DEPTH(DEPTH), .PC_W(PC_W)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    pctrace_walker #(.DEPTH(DEPTH), .PC_W(PC_W)) u_walker (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .dump_req  (dump_req),
        .start_ptr (wr_addr),
        .rd_addr   (rd_addr),
        .slot_data (rd_data),
        .rec_valid (rec_valid),
        .rec_ready (rec_ready),
        .rec_pc    (rec_pc),
        .rec_count (rec_count),
        .busy      (busy)
    );

    AST_FROZEN_TOP: assert property (@(posedge clk) disable iff (rst || clear)
        busy |-> !wr_en || !step_vld); // R8

endmodule

// File: tb/pctrace_recorder_tb.sv
module pctrace_recorder_tb;

    localparam int DECIM = 3;
    localparam int DEPTH = 8;
    localparam int PC_W  = 32;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             clear = 1'b0;
    logic             step_vld = 1'b0;
    logic [PC_W-1:0]  step_pc = '0;
    logic             dump_req = 1'b0;
    logic             rec_ready = 1'b0;
    logic             rec_valid;
    logic [PC_W-1:0]  rec_pc;
    logic [CNT_W-1:0] rec_count;
    logic             busy;

    always #2.5 clk = ~clk;

    pctrace_recorder #(.DECIM(DECIM), .DEPTH(DEPTH), .PC_W(PC_W)) u_dut (
        .clk(clk), .rst(rst), .clear(clear), .step_vld(step_vld), .step_pc(step_pc),
        .dump_req(dump_req), .rec_ready(rec_ready), .rec_valid(rec_valid),
        .rec_pc(rec_pc), .rec_count(rec_count), .busy(busy)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] mdl [DEPTH];
    int          mwp = 0;
    int          msc = 0;
    logic [15:0] lfsr = 16'hACE1;

    logic [31:0] exp_pc  [DEPTH];
    int          exp_cnt [DEPTH];
    int          n_exp;

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        mwp = 0;
        msc = 0;
    endtask

    // one accepted step (R2, R3)
    task automatic do_step(input logic [31:0] pc);
        @(negedge clk);
        step_vld = 1'b1;
        step_pc  = pc;
        @(negedge clk);
        step_vld = 1'b0;
        msc++;
        if (msc == DECIM) begin
            mdl[mwp] = pc;
            mwp = (mwp + 1) % DEPTH;
            msc = 0;
        end
    endtask

    // expected records: oldest first, zeros dropped, equal neighbours merged (R4, R5, R6)
    task automatic build_expected();
        bit          open = 0;
        logic [31:0] rp = '0;
        int          rc = 0;
        n_exp = 0;
        for (int j = 0; j < DEPTH; j++) begin
            logic [31:0] v = mdl[(mwp + j) % DEPTH];
            if (v != 0) begin
                if (open && v == rp) rc++;
                else begin
                    if (open) begin exp_pc[n_exp] = rp; exp_cnt[n_exp] = rc; n_exp++; end
                    open = 1; rp = v; rc = 1;
                end
            end
        end
        if (open) begin exp_pc[n_exp] = rp; exp_cnt[n_exp] = rc; n_exp++; end
    endtask

    function automatic bit ready_pat(input int mode, input int k, input logic [15:0] r);
        case (mode)
            0: return 1'b1;
            1: return k[0];
            2: return (k % 4) == 3;
            default: return r[3];
        endcase
    endfunction

    task automatic do_dump(input int mode, input bit inject, input bit extra);
        int          got = 0;
        bit          held = 0;
        logic [31:0] hpc = '0;
        logic [CNT_W-1:0] hcnt = '0;
        build_expected();
        @(negedge clk);
        dump_req = 1'b1;
        @(negedge clk);
        dump_req = 1'b0;
        for (int k = 0; k < 400; k++) begin
            if (!busy) break;
            lfsr = lfsr_next(lfsr);
            rec_ready = ready_pat(mode, k, lfsr);
            step_vld  = inject;
            step_pc   = 32'h0000_0F00 + 32'(k);
            dump_req  = extra && (k % 3 == 0);
            #1;
            if (held) begin
                chk(rec_valid && rec_pc == hpc && rec_count == hcnt, "R7 hold",
                    {rec_valid, rec_pc}, {1'b1, hpc});
            end
            held = rec_valid && !rec_ready;
            hpc  = rec_pc;
            hcnt = rec_count;
            if (rec_valid && rec_ready) begin
                if (got < n_exp) begin
                    chk(rec_pc == exp_pc[got], "R4 record pc", rec_pc, exp_pc[got]);
                    chk(int'(rec_count) == exp_cnt[got], "R6 record count", rec_count, exp_cnt[got]);
                end else begin
                    chk(1'b0, "R5 extra record", rec_pc, 0);
                end
                got++;
            end
            @(negedge clk);
        end
        step_vld  = 1'b0;
        dump_req  = 1'b0;
        rec_ready = 1'b0;
        chk(got == n_exp, "R4 record total", got, n_exp);
        if (extra) begin
            repeat (3) @(negedge clk);
            chk(!busy && !rec_valid, "R9 no second walk", {busy, rec_valid}, 0);
        end
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!busy && !rec_valid, "R1 reset outputs", {busy, rec_valid}, 0);
        do_dump(0, 0, 0);                       // R1: empty history

        do_step(32'h10);
        do_step(32'h14);
        do_dump(1, 0, 0);                       // R2: not yet sampled
        do_step(32'h18);
        do_dump(0, 0, 0);                       // R2: one record 0x18

        // sweep: small alphabet with zero, wraps, merges, backpressure (R3..R9)
        for (int it = 0; it < 80; it++) begin
            int ns = (it % 6) + 1;
            for (int s = 0; s < ns; s++) begin
                for (int t = 0; t < DECIM - 1; t++) do_step(32'h0000_2000 + 32'(t));
                lfsr = lfsr_next(lfsr);
                do_step((lfsr[1:0] == 0) ? 32'h0 : (32'h40 + 32'(lfsr[1:0]) * 4));
            end
            do_dump(it % 4, (it % 3) == 0, (it % 2) == 1);
        end

        // R8: steps during walks must not have moved the counter
        do_step(32'h0000_7770);
        do_step(32'h0000_7774);
        do_step(32'h0000_7778);
        do_dump(0, 0, 0);

        // R10: clear during a stalled walk
        @(negedge clk);
        dump_req = 1'b1;
        @(negedge clk);
        dump_req = 1'b0;
        rec_ready = 1'b0;
        repeat (DEPTH) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        model_clear();
        chk(!busy && !rec_valid, "R10 clear aborts walk", {busy, rec_valid}, 0);
        do_dump(2, 0, 0);
        do_step(32'h30);
        do_step(32'h34);
        do_dump(0, 0, 0);
        do_step(32'h38);
        do_dump(3, 0, 0);                       // R10: counter restarted

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule